// File: doc/BRIEF.md
# Receiver Polling Mode Controller

This block sequences a low-power radio receiver through four operating modes: sleep, start-up, bit-check and receive. In normal polling the receiver sleeps for a programmed number of base timer ticks, powers up for a fixed start-up interval, and then checks the incoming edge intervals. It enters receive mode once enough consecutive valid intervals have arrived. Any invalid interval sends it back to sleep for another polling round.

An active-low control pin overrides the polling cycle. Holding the pin low for a fixed number of clock cycles forces start-up from any mode. While the override is in force, the programmed sleep time and interval count play no part: start-up leads straight to receive. To hand control back to polling, the pin must stay low for a minimum time and then go high. Polling then resumes from sleep after a fixed delay counted from the rising edge. A sleep code with every bit set, which is 31 for the default width, keeps the receiver asleep for as long as the pin stays high.

The controller owns all of its own counters: the sleep tick counter, the start-up tick counter, the valid-interval counter, and the low-time and rise-delay counters for the pin. The interval measurement itself is done elsewhere. Its result arrives here as a strobe together with a valid flag.

Top module: `rx_poll_ctrl`

## Requirements
- R1: After reset the mode output is sleep (code 0), and active, startupEn and checkEn are all low.
- R2: The mode codes are 0 for sleep, 1 for start-up, 2 for bit-check and 3 for receive. The active output is high in every mode except sleep. The startupEn output is high only in start-up, and checkEn is high only in bit-check.
- R3: In polling, sleep lasts until sleepCode tick pulses have been counted since sleep was entered. Start-up follows on the next clock edge. A code of 0 leaves sleep on the first edge after entry.
- R4: While the pin is high, a sleepCode of all ones (31 at the default width) keeps the mode at sleep however many ticks arrive.
- R5: Start-up lasts STARTUP_TICKS tick pulses (default 3). In polling it then moves to bit-check on the next edge.
- R6: Bit-check moves to receive on the edge after the checkCount-th valid interval strobe. If an invalid strobe arrives in that same cycle, the move to receive still wins.
- R7: In bit-check, an invalid interval strobe (ivStrobe high with ivOk low) returns the mode to sleep on that edge, with the sleep count restarted.
- R8: When the pin has been sampled low on ON_DELAY consecutive clock edges (default 4), the mode becomes start-up on the last of those edges. This happens from any mode, including permanent sleep.
- R9: Under pin override, start-up moves to receive after its ticks, and checkCount is not used.
- R10: After the pin has been low for at least MIN_LOW edges (default 12), OFF_DELAY edges with the pin high (default 6) end the override. The mode returns to sleep and polling resumes with the programmed sleepCode.
- R11: A low period shorter than MIN_LOW edges, followed by a rise, does not end the override, and the mode stays where it was.
- R12: If the pin override expires in the same cycle as an invalid interval strobe in bit-check, the override wins and the mode becomes start-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pollOnN | input | 1 | Active-low override pin, already synchronous to clk |
| sleepCode | input | SLEEP_W | Sleep time in base ticks; all ones means permanent sleep |
| checkCount | input | CNT_W | Number of consecutive valid intervals needed to pass bit-check |
| tick | input | 1 | Base timer tick, one cycle wide |
| ivStrobe | input | 1 | An edge interval has been measured this cycle |
| ivOk | input | 1 | The measured interval lies inside the window |
| mode | output | 2 | Current mode code |
| startupEn | output | 1 | Start-up stage enable |
| checkEn | output | 1 | Bit-check stage enable |
| active | output | 1 | High in every mode except sleep |

## Verification
Two events can fall in the same clock cycle. The pin override can expire while bit-check is receiving an invalid interval, and a bit-check pass can become due while an invalid interval arrives. The bench provokes the first case by holding the pin low for one edge less than the entry delay and then pulsing an invalid strobe on the final edge. It provokes the second by sending exactly checkCount valid strobes and then an invalid one in the following cycle. In each case the scoreboard expects a single mode change, to start-up for the first and to receive for the second, and any detour through sleep is reported as an unexpected mode.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_CHECK   = 2'd2,
    MODE_RECV    = 2'd3
  } rxMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrSleep;
    logic clrStart;
    logic clrCheck;
    logic runSleep;
    logic runStart;
    logic runCheck;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic onHit;
    logic offHit;
    logic sleepDone;
    logic startDone;
    logic checkPass;
    logic checkFail;
  } dpStatus_t;

endpackage

// File: rtl/rx_poll_dp.sv
module rx_poll_dp
  import rx_poll_pkg::*;
#(
  parameter int SLEEP_W       = 5,
  parameter int CNT_W         = 4,
  parameter int STARTUP_TICKS = 3,
  parameter int ON_DELAY      = 4,
  parameter int MIN_LOW       = 12,
  parameter int OFF_DELAY     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pollOnN,
  input  logic [SLEEP_W-1:0] sleepCode,
  input  logic [CNT_W-1:0]   checkCount,
  input  logic               tick,
  input  logic               ivStrobe,
  input  logic               ivOk,
  input  ctlStrobe_t         ctl,
  output dpStatus_t          stat
);

  localparam int LOW_CAP = (ON_DELAY > MIN_LOW) ? ON_DELAY : MIN_LOW;
  localparam int LOW_W   = $clog2(LOW_CAP + 1);
  localparam int RISE_W  = $clog2(OFF_DELAY + 1);
  localparam int ST_W    = $clog2(STARTUP_TICKS + 1);

  localparam logic [LOW_W-1:0]   LOW_MAX   = LOW_W'(LOW_CAP);
  localparam logic [LOW_W-1:0]   ON_LAST   = LOW_W'(ON_DELAY - 1);
  localparam logic [LOW_W-1:0]   ARM_LAST  = LOW_W'(MIN_LOW - 1);
  localparam logic [RISE_W-1:0]  RISE_MAX  = RISE_W'(OFF_DELAY);
  localparam logic [RISE_W-1:0]  RISE_LAST = RISE_W'(OFF_DELAY - 1);
  localparam logic [ST_W-1:0]    ST_END    = ST_W'(STARTUP_TICKS);
  localparam logic [SLEEP_W-1:0] FOREVER   = '1;
  localparam logic [CNT_W-1:0]   VALID_MAX = '1;

  logic [LOW_W-1:0]   lowCnt;
  logic [RISE_W-1:0]  riseCnt;
  logic               armed;
  logic [SLEEP_W-1:0] sleepCnt;
  logic [ST_W-1:0]    startCnt;
  logic [CNT_W-1:0]   validCnt;

  // pin low-time counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (pollOnN)         lowCnt <= '0;
    else if (lowCnt != LOW_MAX) lowCnt <= lowCnt + 1'b1;
  end

  // armed once the pin has been low long enough to allow an exit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 armed <= 1'b0;
    else if (stat.offHit)                      armed <= 1'b0;
    else if (!pollOnN && lowCnt >= ARM_LAST)   armed <= 1'b1;
  end

  // delay after the rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      riseCnt <= '0;
    else if (!pollOnN || !armed)    riseCnt <= '0;
    else if (riseCnt != RISE_MAX)   riseCnt <= riseCnt + 1'b1;
  end

  // sleep tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          sleepCnt <= '0;
    else if (ctl.clrSleep)                              sleepCnt <= '0;
    else if (ctl.runSleep && tick && sleepCnt != FOREVER) sleepCnt <= sleepCnt + 1'b1;
  end

  // start-up tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         startCnt <= '0;
    else if (ctl.clrStart)                             startCnt <= '0;
    else if (ctl.runStart && tick && startCnt != ST_END) startCnt <= startCnt + 1'b1;
  end

  // consecutive valid interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          validCnt <= '0;
    else if (ctl.clrCheck) validCnt <= '0;
    else if (ctl.runCheck && ivStrobe && ivOk && validCnt != VALID_MAX)
      validCnt <= validCnt + 1'b1;
  end

  always_comb begin
    stat.onHit     = !pollOnN && (lowCnt == ON_LAST);
    stat.offHit    = pollOnN && armed && (riseCnt == RISE_LAST);
    stat.sleepDone = ctl.runSleep && pollOnN && (sleepCode != FOREVER)
                     && (sleepCnt >= sleepCode);
    stat.startDone = ctl.runStart && (startCnt >= ST_END);
    stat.checkPass = ctl.runCheck && (validCnt >= checkCount);
    stat.checkFail = ctl.runCheck && ivStrobe && !ivOk;
  end

endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
  import rx_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpStatus_t  stat,
  output ctlStrobe_t ctl,
  output rxMode_t    state
);

  rxMode_t nxt;
  logic    override, ovrNxt;

  always_comb begin
    nxt    = state;
    ovrNxt = override;
    if (stat.onHit) begin
      nxt    = MODE_STARTUP;
      ovrNxt = 1'b1;
    end else if (stat.offHit && override) begin
      nxt    = MODE_SLEEP;
      ovrNxt = 1'b0;
    end else begin
      unique case (state)
        MODE_SLEEP:   if (stat.sleepDone) nxt = MODE_STARTUP;
        MODE_STARTUP: if (stat.startDone) nxt = override ? MODE_RECV : MODE_CHECK;
        MODE_CHECK: begin
          if (stat.checkPass)      nxt = MODE_RECV;
          else if (stat.checkFail) nxt = MODE_SLEEP;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl.clrSleep = (nxt == MODE_SLEEP) && (state != MODE_SLEEP);
    ctl.clrStart = (nxt == MODE_STARTUP) && ((state != MODE_STARTUP) || stat.onHit);
    ctl.clrCheck = (nxt == MODE_CHECK) && (state != MODE_CHECK);
    ctl.runSleep = (state == MODE_SLEEP);
    ctl.runStart = (state == MODE_STARTUP);
    ctl.runCheck = (state == MODE_CHECK);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= MODE_SLEEP;
      override <= 1'b0;
    end else begin
      state    <= nxt;
      override <= ovrNxt;
    end
  end

endmodule

// File: rtl/rx_poll_ctrl.sv
module rx_poll_ctrl
  import rx_poll_pkg::*;
#(
  parameter int SLEEP_W       = 5,
  parameter int CNT_W         = 4,
  parameter int STARTUP_TICKS = 3,
  parameter int ON_DELAY      = 4,
  parameter int MIN_LOW       = 12,
  parameter int OFF_DELAY     = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pollOnN,
  input  logic [SLEEP_W-1:0] sleepCode,
  input  logic [CNT_W-1:0]   checkCount,
  input  logic               tick,
  input  logic               ivStrobe,
  input  logic               ivOk,
  output logic [1:0]         mode,
  output logic               startupEn,
  output logic               checkEn,
  output logic               active
);

  ctlStrobe_t ctl;
  dpStatus_t  stat;
  rxMode_t    state;

  rx_poll_dp #(
    .SLEEP_W(SLEEP_W), .CNT_W(CNT_W), .STARTUP_TICKS(STARTUP_TICKS),
    .ON_DELAY(ON_DELAY), .MIN_LOW(MIN_LOW), .OFF_DELAY(OFF_DELAY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pollOnN(pollOnN), .sleepCode(sleepCode),
    .checkCount(checkCount), .tick(tick), .ivStrobe(ivStrobe), .ivOk(ivOk),
    .ctl(ctl), .stat(stat)
  );

  rx_poll_fsm u_fsm (
    .clk(clk), .rstN(rstN), .stat(stat), .ctl(ctl), .state(state)
  );

  assign mode      = state;
  assign startupEn = (state == MODE_STARTUP);
  assign checkEn   = (state == MODE_CHECK);
  assign active    = (state != MODE_SLEEP);

endmodule

// File: rtl/rx_poll_chk.sv
module rx_poll_chk #(
  parameter int SLEEP_W = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               pollOnN,
  input logic [SLEEP_W-1:0] sleepCode,
  input logic               ivStrobe,
  input logic               ivOk,
  input logic [1:0]         mode,
  input logic               startupEn,
  input logic               checkEn
);

  // R4
  perm_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && sleepCode == '1 && pollOnN) |=> (mode == 2'd0));

  // R3
  sleep_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |=> (mode == 2'd0 || mode == 2'd1));

  // R6
  no_direct_recv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0) |=> (mode != 2'd3));

  // R7
  fail_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && ivStrobe && !ivOk && pollOnN) |=> (mode == 2'd0 || mode == 2'd3));

  // R2
  stage_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startupEn, checkEn}));

endmodule

bind rx_poll_ctrl rx_poll_chk #(.SLEEP_W(SLEEP_W)) u_chk (
  .clk(clk), .rstN(rstN), .pollOnN(pollOnN), .sleepCode(sleepCode),
  .ivStrobe(ivStrobe), .ivOk(ivOk), .mode(mode),
  .startupEn(startupEn), .checkEn(checkEn)
);

// File: tb/sim_rx_poll_ctrl.sv
module sim_rx_poll_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int ON_DELAY   = 4;
  localparam int MIN_LOW    = 12;
  localparam int OFF_DELAY  = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pollOnN = 1'b1;
  logic [4:0] sleepCode = 5'd31;
  logic [3:0] checkCount = 4'd2;
  logic       tick = 1'b0;
  logic       ivStrobe = 1'b0;
  logic       ivOk = 1'b0;
  logic [1:0] mode;
  logic       startupEn, checkEn, active;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] expQ[$];
  string      tagQ[$];
  logic [1:0] lastMode = 2'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_poll_ctrl u0 (
    .clk(clk), .rstN(rstN), .pollOnN(pollOnN), .sleepCode(sleepCode),
    .checkCount(checkCount), .tick(tick), .ivStrobe(ivStrobe), .ivOk(ivOk),
    .mode(mode), .startupEn(startupEn), .checkEn(checkEn), .active(active)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseTick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulseIv(input logic ok);
    ivStrobe = 1'b1;
    ivOk = ok;
    @(negedge clk);
    ivStrobe = 1'b0;
    ivOk = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic expectMode(input logic [1:0] m, input string tag);
    expQ.push_back(m);
    tagQ.push_back(tag);
  endtask

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor side of the scoreboard: one item per mode change
  always @(negedge clk) begin
    if (rstN && mode != lastMode) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected mode change: actual %0d expected %0d", mode, lastMode);
      end else begin
        logic [1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (e != mode) begin
          errors++;
          $display("FAIL %s: actual %0d expected %0d", t, mode, e);
        end
      end
      lastMode = mode;
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1
    checkVal("R1 mode", mode, 0);
    checkVal("R1 active", active, 0);
    checkVal("R1 startupEn", startupEn, 0);
    checkVal("R1 checkEn", checkEn, 0);

    // R4: all-ones code never leaves sleep
    for (int i = 0; i < 40; i++) pulseTick();
    step(3);
    checkVal("R4 permanent sleep", mode, 0);

    // R8: override from permanent sleep
    pollOnN = 1'b0;
    step(ON_DELAY - 1);
    checkVal("R8 before delay", mode, 0);
    expectMode(2'd1, "R8");
    step(1);
    checkVal("R8 startup", mode, 1);
    checkVal("R2 active in startup", active, 1);
    checkVal("R2 startupEn", startupEn, 1);

    // R9: override start-up goes straight to receive
    pulseTick(); pulseTick(); pulseTick();
    checkVal("R9 still startup", mode, 1);
    expectMode(2'd3, "R9");
    step(1);
    checkVal("R9 receive", mode, 3);

    // R11: low period shorter than MIN_LOW, then rise
    pollOnN = 1'b1;
    step(20);
    checkVal("R11 override kept", mode, 3);

    // R10: long low then rise ends override
    pollOnN = 1'b0;
    expectMode(2'd1, "R8 from receive");
    step(ON_DELAY);
    sleepCode = 5'd2;
    step(MIN_LOW);
    checkVal("R8 held startup", mode, 1);
    pollOnN = 1'b1;
    step(OFF_DELAY - 1);
    checkVal("R10 before delay", mode, 1);
    expectMode(2'd0, "R10");
    step(1);
    checkVal("R10 sleep", mode, 0);

    // R3: sleep code 2
    pulseTick();
    checkVal("R3 after one tick", mode, 0);
    pulseTick();
    checkVal("R3 after two ticks", mode, 0);
    expectMode(2'd1, "R3");
    step(1);
    checkVal("R3 startup", mode, 1);

    // R5
    pulseTick(); pulseTick();
    checkVal("R5 two ticks", mode, 1);
    pulseTick();
    expectMode(2'd2, "R5");
    step(1);
    checkVal("R5 bitcheck", mode, 2);
    checkVal("R2 checkEn", checkEn, 1);

    // R7: invalid interval returns to sleep; code 0 leaves at once
    pulseIv(1'b1);
    sleepCode = 5'd0;
    expectMode(2'd0, "R7");
    pulseIv(1'b0);
    checkVal("R7 sleep", mode, 0);
    expectMode(2'd1, "R3 code 0");
    step(1);
    checkVal("R3 code 0 startup", mode, 1);
    pulseTick(); pulseTick(); pulseTick();
    expectMode(2'd2, "R5");
    step(1);

    // R6: pass beats a same-cycle invalid strobe
    pulseIv(1'b1);
    pulseIv(1'b1);
    checkVal("R6 still bitcheck", mode, 2);
    expectMode(2'd3, "R6");
    pulseIv(1'b0);
    checkVal("R6 receive", mode, 3);

    // back to polling for R12
    pollOnN = 1'b0;
    expectMode(2'd1, "R8");
    step(ON_DELAY);
    step(MIN_LOW);
    pollOnN = 1'b1;
    expectMode(2'd0, "R10");
    step(OFF_DELAY);
    checkVal("R10 sleep again", mode, 0);
    expectMode(2'd1, "R3");
    step(1);
    pulseTick(); pulseTick(); pulseTick();
    expectMode(2'd2, "R5");
    step(1);
    checkVal("R12 in bitcheck", mode, 2);

    // R12: override entry and invalid strobe on the same edge
    pollOnN = 1'b0;
    step(ON_DELAY - 1);
    expectMode(2'd1, "R12");
    pulseIv(1'b0);
    checkVal("R12 startup", mode, 1);
    pollOnN = 1'b1;
    pulseTick(); pulseTick(); pulseTick();
    expectMode(2'd3, "R9");
    step(1);
    checkVal("R9 receive again", mode, 3);

    step(2);
    checkVal("scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule